// File: doc/BRIEF.md
# Wait-State Sequencer for Slow Peripherals

This block lengthens processor bus cycles that reach a slow peripheral. While the device select is active, it pulls the processor ready line low for a fixed number of clock cycles. It also shapes the read and write strobes sent to the device. The core is a small synchronous up-counter that can be loaded. When the device is not selected, the counter sits at its all-ones terminal value. An access that starts from that value loads a programmable start value, and the counter then counts up to terminal again. The start value sets how many cycles the access lasts. Ready is decoded from the count one step ahead, so no comparator against a wait count is needed.

One counter bit, taken in its low state, serves as a timed enable. The device strobes are active only while this enable is active and the device is selected. The result is a single continuous strobe pulse that starts after the access begins and ends before the access completes. This gives the peripheral extra address setup and hold time, with no need to qualify the strobe by a clock phase. The bus direction input chooses which of the two strobes is used.

Top module: `wait_seq`

## Requirements
- R1: A synchronous active-high reset forces the count to all ones. In the first cycle after reset, with the device deselected, ready is 1, the enable is 0, and both strobes are 1.
- R2: While the device select is high and the count is all ones, the count stays there. Ready stays 1, the enable stays 0, and both strobes stay 1, so no cycle is stretched.
- R3: If the device select is low in a cycle where the count is all ones, that cycle's ready is 0 and the next count is the parameter `LOAD_SEL`. Any count below all ones advances by one per clock. Ready is 1 only when the count is all ones minus one, or when it is all ones with the select high. An access therefore lasts 2^CNT_W − LOAD_SEL cycles, counting the final cycle in which ready is 1.
- R4: With `LOAD_SEL` = 14 and a 4-bit counter, an access lasts 2 cycles in total.
- R5: With `LOAD_SEL` = 11 and a 4-bit counter, an access lasts 5 cycles in total.
- R6: The timed enable is 1 exactly when counter bit `EN_BIT` is 0.
- R7: The read strobe (active low) is 0 only while the enable is 1, the select is low, and the direction input is 1 (read). The write strobe is 0 only under the same conditions with the direction input 0 (write). Both strobes are 1 whenever the select is high.
- R8: Within one access, the active strobe falls at most once and rises at most once. It forms one continuous low pulse, never a train of pulses.
- R9: In the first cycle of every access (count all ones), both strobes are 1. With `LOAD_SEL` = 11 and `EN_BIT` = 1, both strobes are also 1 in the final (ready) cycle. With these settings the strobe is low in cycles 3 and 4 of the 5-cycle access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_sel_n | input | 1 | Device select from address decoding, active low |
| cpu_rnw | input | 1 | Bus direction: 1 read, 0 write |
| cpu_rdy | output | 1 | Ready to the processor, active high |
| timed_en | output | 1 | Timed enable taken from the counter bit |
| dev_rd_n | output | 1 | Gated read strobe to the device, active low |
| dev_wr_n | output | 1 | Gated write strobe to the device, active low |

## Verification
Every output is decoded from the count register and the current inputs. Ready, the enable and the strobes are therefore due in the same cycle as the select and direction that produce them. The count moves one rising edge later. The bench changes inputs on the falling edge and samples all outputs 1 ns later. It advances its own count model only at the rising edge, so each sample is compared against the model state that the design holds at that moment. Access length, strobe continuity and the setup and hold cycles are measured by counting sampled cycles from the moment the select goes low until ready is seen high.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  // Strobe bundle produced by the gating stage
  typedef struct packed {
    logic en;
    logic rd_n;
    logic wr_n;
  } wsq_strb_t;

  // Total cycles of one stretched access, final ready cycle included
  function automatic int access_cycles(input int cnt_w, input int load_val);
    return (1 << cnt_w) - load_val;
  endfunction

endpackage

// File: rtl/wsq_counter.sv
module wsq_counter #(
  parameter int CNT_W    = 4,
  parameter int LOAD_SEL = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  output logic [CNT_W-1:0] count,
  output logic             at_term
);
  localparam logic [CNT_W-1:0] TERM   = '1;
  localparam logic [CNT_W-1:0] LOAD_V = LOAD_SEL[CNT_W-1:0];

  logic [CNT_W-1:0] count_q;

  assign at_term = (count_q == TERM);
  assign count   = count_q;

  // Load at terminal count, otherwise count upward
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= TERM;
    end else if (at_term) begin
      count_q <= start_req ? LOAD_V : TERM;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/wsq_ready.sv
module wsq_ready #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] count,
  input  logic             at_term,
  input  logic             dev_sel_n,
  output logic             rdy
);
  localparam logic [CNT_W-1:0] NEAR = {{(CNT_W-1){1'b1}}, 1'b0};

  // Look-ahead terminal count: ready when the next count is terminal
  always_comb begin
    rdy = (count == NEAR) | (at_term & dev_sel_n);
  end
endmodule

// File: rtl/wsq_strobe.sv
module wsq_strobe
  import wsq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int EN_BIT = 1
) (
  input  logic [CNT_W-1:0] count,
  input  logic             dev_sel_n,
  input  logic             cpu_rnw,
  output wsq_strb_t        strb
);
  logic en;
  logic go;

  // Idle count is all ones, so a low bit can never enable at idle
  assign en = ~count[EN_BIT];
  assign go = en & ~dev_sel_n;

  always_comb begin
    strb.en   = en;
    strb.rd_n = ~(go & cpu_rnw);
    strb.wr_n = ~(go & ~cpu_rnw);
  end
endmodule

// File: rtl/wait_seq.sv
module wait_seq
  import wsq_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int LOAD_SEL = 11,
  parameter int EN_BIT   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic dev_sel_n,
  input  logic cpu_rnw,
  output logic cpu_rdy,
  output logic timed_en,
  output logic dev_rd_n,
  output logic dev_wr_n
);
  logic [CNT_W-1:0] count_q;
  logic             at_term;
  wsq_strb_t        strb;

  wsq_counter #(
    .CNT_W   (CNT_W),
    .LOAD_SEL(LOAD_SEL)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .start_req(~dev_sel_n),
    .count    (count_q),
    .at_term  (at_term)
  );

  wsq_ready #(
    .CNT_W(CNT_W)
  ) u_rdy (
    .count    (count_q),
    .at_term  (at_term),
    .dev_sel_n(dev_sel_n),
    .rdy      (cpu_rdy)
  );

  wsq_strobe #(
    .CNT_W (CNT_W),
    .EN_BIT(EN_BIT)
  ) u_strb (
    .count    (count_q),
    .dev_sel_n(dev_sel_n),
    .cpu_rnw  (cpu_rnw),
    .strb     (strb)
  );

  assign timed_en = strb.en;
  assign dev_rd_n = strb.rd_n;
  assign dev_wr_n = strb.wr_n;
endmodule

// File: rtl/wait_seq_chk.sv
module wait_seq_chk
  import wsq_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int LOAD_SEL = 11,
  parameter int EN_BIT   = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             dev_sel_n,
  input logic             cpu_rnw,
  input logic             cpu_rdy,
  input logic             timed_en,
  input logic             dev_rd_n,
  input logic             dev_wr_n,
  input logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TERM   = '1;
  localparam logic [CNT_W-1:0] NEAR   = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0] LOAD_V = LOAD_SEL[CNT_W-1:0];
  localparam int               CYC_W  = CNT_W + 1;
  localparam int               ACC    = access_cycles(CNT_W, LOAD_SEL);
  localparam logic [CYC_W-1:0] LAST_C = CYC_W'(ACC - 1);

  logic             seen_q;
  logic [CYC_W-1:0] cyc_q;
  logic             low_now;
  logic             low_q;
  logic             ended_q;

  assign low_now = ~dev_rd_n | ~dev_wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b1;
      cyc_q   <= '0;
      low_q   <= 1'b0;
      ended_q <= 1'b0;
    end else begin
      cyc_q   <= (count == TERM) ? CYC_W'(1) : cyc_q + 1'b1;
      low_q   <= low_now;
      ended_q <= (count == TERM) ? 1'b0 : (ended_q | (low_q & ~low_now));
    end
  end

  a_r1_reset_to_idle: assert property (@(posedge clk) disable iff (rst)
    seen_q && $past(rst) |-> count == TERM);

  a_r2_idle_ready: assert property (@(posedge clk) disable iff (rst)
    count == TERM && dev_sel_n |-> cpu_rdy && !timed_en && dev_rd_n && dev_wr_n);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    seen_q && count == TERM && dev_sel_n |=> count == TERM);

  a_r3_stretch: assert property (@(posedge clk) disable iff (rst)
    count == TERM && !dev_sel_n |-> !cpu_rdy);

  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    seen_q && count == TERM && !dev_sel_n |=> count == LOAD_V);

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    seen_q && count != TERM |=> count == $past(count) + 1'b1);

  a_r3_length: assert property (@(posedge clk) disable iff (rst)
    seen_q && count != TERM && cpu_rdy |-> cyc_q == LAST_C);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!dev_rd_n && !dev_wr_n));

  a_r7_gated: assert property (@(posedge clk) disable iff (rst)
    (!dev_rd_n || !dev_wr_n) |-> timed_en && !dev_sel_n && (cpu_rnw == !dev_rd_n));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ended_q |-> dev_rd_n && dev_wr_n);

  a_r9_setup: assert property (@(posedge clk) disable iff (rst)
    count == TERM |-> dev_rd_n && dev_wr_n);

  generate
    if (EN_BIT != 0) begin : g_hold
      a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        count == NEAR |-> dev_rd_n && dev_wr_n);
    end
  endgenerate
endmodule

bind wait_seq wait_seq_chk #(
  .CNT_W   (CNT_W),
  .LOAD_SEL(LOAD_SEL),
  .EN_BIT  (EN_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dev_sel_n(dev_sel_n),
  .cpu_rnw  (cpu_rnw),
  .cpu_rdy  (cpu_rdy),
  .timed_en (timed_en),
  .dev_rd_n (dev_rd_n),
  .dev_wr_n (dev_wr_n),
  .count    (count_q)
);

// File: tb/wait_seq_tb.sv
module wait_seq_tb;
  localparam int LOAD_A = 11;
  localparam int EN_A   = 1;
  localparam int LOAD_B = 14;
  localparam int EN_B   = 0;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst     = 1'b1;
  logic sel_a_n = 1'b1;
  logic sel_b_n = 1'b1;
  logic rnw     = 1'b1;
  logic rdy_a, en_a, rd_a_n, wr_a_n;
  logic rdy_b, en_b, rd_b_n, wr_b_n;

  wait_seq #(.CNT_W(4), .LOAD_SEL(LOAD_A), .EN_BIT(EN_A)) u_dut (
    .clk(clk), .rst(rst), .dev_sel_n(sel_a_n), .cpu_rnw(rnw),
    .cpu_rdy(rdy_a), .timed_en(en_a), .dev_rd_n(rd_a_n), .dev_wr_n(wr_a_n));

  wait_seq #(.CNT_W(4), .LOAD_SEL(LOAD_B), .EN_BIT(EN_B)) u_dut_short (
    .clk(clk), .rst(rst), .dev_sel_n(sel_b_n), .cpu_rnw(rnw),
    .cpu_rdy(rdy_b), .timed_en(en_b), .dev_rd_n(rd_b_n), .dev_wr_n(wr_b_n));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] m_a = 4'hF;
  logic [3:0] m_b = 4'hF;
  logic [3:0] snap_a, snap_b;

  // Expected {ready, enable, rd_n, wr_n} from the requirements
  function automatic logic [3:0] exp_out(logic [3:0] c, logic s_n, logic r, int enb);
    logic rd, en, go;
    rd = (c == 4'hE) | ((c == 4'hF) & s_n);
    en = ~c[enb];
    go = en & ~s_n;
    return {rd, en, ~(go & r), ~(go & ~r)};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // One cycle: sample just after the falling edge, then advance the model
  task automatic step();
    logic [3:0] ea, eb;
    #1;
    snap_a = {rdy_a, en_a, rd_a_n, wr_a_n};
    snap_b = {rdy_b, en_b, rd_b_n, wr_b_n};
    if (!rst) begin
      ea = exp_out(m_a, sel_a_n, rnw, EN_A);
      eb = exp_out(m_b, sel_b_n, rnw, EN_B);
      chk(snap_a == ea, sel_a_n ? "R2" : "R3 R6 R7", "outputs long", int'(snap_a), int'(ea));
      chk(snap_b == eb, sel_b_n ? "R2" : "R3 R6 R7", "outputs short", int'(snap_b), int'(eb));
    end
    @(posedge clk);
    m_a = rst ? 4'hF : (m_a == 4'hF ? (sel_a_n ? 4'hF : 4'(LOAD_A)) : m_a + 4'd1);
    m_b = rst ? 4'hF : (m_b == 4'hF ? (sel_b_n ? 4'hF : 4'(LOAD_B)) : m_b + 4'd1);
    @(negedge clk);
  endtask

  // Processor-like access: hold select until ready is seen high
  task automatic do_access(input int which, input logic rw);
    int  n = 0;
    int  falls = 0;
    logic prev = 1'b1;
    logic str_first = 1'b0;
    logic str_last = 1'b0;
    logic str;
    bit  got = 1'b0;
    rnw = rw;
    if (which == 0) sel_a_n = 1'b0; else sel_b_n = 1'b0;
    while (!got && n < 40) begin
      step();
      n++;
      str = (which == 0) ? (snap_a[1] & snap_a[0]) : (snap_b[1] & snap_b[0]);
      if (n == 1) str_first = str;
      if (prev && !str) falls++;
      prev = str;
      str_last = str;
      got = (which == 0) ? snap_a[3] : snap_b[3];
    end
    if (which == 0) begin
      sel_a_n = 1'b1;
      chk(n == 16 - LOAD_A, "R5", "access length", n, 16 - LOAD_A);
      chk(falls == 1, "R8", "strobe falling edges", falls, 1);
      chk(str_first == 1'b1, "R9", "strobe in first cycle", int'(str_first), 1);
      chk(str_last == 1'b1, "R9", "strobe in ready cycle", int'(str_last), 1);
    end else begin
      sel_b_n = 1'b1;
      chk(n == 16 - LOAD_B, "R4", "access length", n, 16 - LOAD_B);
      chk(falls <= 1, "R8", "strobe falling edges", falls, 1);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    #1;
    chk(rdy_a && !en_a && rd_a_n && wr_a_n, "R1", "idle after reset long",
        int'({rdy_a, en_a, rd_a_n, wr_a_n}), 4'b1011);
    chk(rdy_b && !en_b && rd_b_n && wr_b_n, "R1", "idle after reset short",
        int'({rdy_b, en_b, rd_b_n, wr_b_n}), 4'b1011);
    repeat (5) step();

    // Directed: reads, writes and back-to-back accesses
    do_access(0, 1'b1);
    step();
    do_access(0, 1'b0);
    do_access(0, 1'b1);
    do_access(0, 1'b0);
    do_access(1, 1'b1);
    do_access(1, 1'b0);
    do_access(1, 1'b1);
    repeat (2) step();

    // Directed: reset in the middle of an access
    sel_a_n = 1'b0;
    rnw = 1'b1;
    repeat (2) step();
    rst = 1'b1;
    sel_a_n = 1'b1;
    step();
    rst = 1'b0;
    #1;
    chk(rdy_a && !en_a && rd_a_n && wr_a_n, "R1", "idle after mid-access reset",
        int'({rdy_a, en_a, rd_a_n, wr_a_n}), 4'b1011);
    step();

    // Random mix with a fixed seed
    begin
      int unsigned seed_v = $urandom(32'd20240611);
      seed_v = seed_v;
    end
    for (int i = 0; i < 80; i++) begin
      int gap = int'($urandom_range(0, 3));
      repeat (gap) step();
      do_access(int'($urandom_range(0, 1)), logic'($urandom_range(0, 1)));
    end
    repeat (4) step();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule